// File: doc/BRIEF.md
# Serial Bus Controller FIFO and Interrupt Front End

This block sits between a register port and the engine of a serial bus controller. Software writes transmit words into a transmit FIFO and reads received words out of a receive FIFO through a small word-addressed register port. The engine pops transmit words and pushes received words on a word-level interface. Each 32-bit word carries four bytes of bus data.

The block reports how full each FIFO is. It raises a data request whenever a FIFO has crossed a trigger level that software programs. It records engine events and FIFO misuse in a sticky status register. It combines that status with a mask to drive one interrupt line. Either FIFO can be flushed from the control register, and the flush bit clears itself once the flush is done.

Top module: `sbfe_fifo_irq_unit`

## Requirements
- R1: After reset, CTRL (address 0) reads 0 and MASK (address 2) reads 0. LEVEL (address 1) reads 0x80. STAT (address 3) reads 0x02, because only the live transmit request is set. `irq` is low and `eng_tx_valid` is low.
- R2: Words written to TXDATA (address 4) reach the engine in the order they were written. `eng_tx_data` shows the oldest word while `eng_tx_valid` is high. `eng_tx_pop` removes that word. A pop while the FIFO is empty has no effect.
- R3: A write to TXDATA while the transmit FIFO holds DEPTH words drops the word and sets STAT bit 5 (transmit overflow).
- R4: Words pushed by the engine on `eng_rx_push` are read from RXDATA (address 5) in order. Each read strobe removes one word. An engine push into a full receive FIFO is dropped and sets no flag.
- R5: A read strobe on RXDATA while the receive FIFO is empty returns 0 and sets STAT bit 4 (receive underflow).
- R6: LEVEL bits 7:4 hold the number of free transmit slots. LEVEL bits 3:0 hold the number of receive words available.
- R7: Writing 1 to CTRL bit 0 flushes the receive FIFO, and writing 1 to CTRL bit 1 flushes the transmit FIFO. The bit reads 1 in the cycle after the write, then reads 0 with the FIFO empty.
- R8: CTRL bits 4:2 hold the receive trigger and bits 7:5 hold the transmit trigger. STAT bit 0 (receive request) is 1 while the receive count is at least the receive trigger plus 1. STAT bit 1 (transmit request) is 1 while the free count is at least the transmit trigger plus 1. Both bits follow the FIFO levels, and writes to STAT do not change them.
- R9: Event pulses set sticky STAT bits: `evt_arb_lost` sets bit 2, `evt_no_ack` sets bit 3, `evt_all_done` sets bit 6 and `evt_pkt_done` sets bit 7. Writing 1 to a sticky bit clears it, and writing 0 leaves it unchanged. When an event and a clear arrive in the same cycle, the event wins.
- R10: `irq` is the OR of all bits of (STAT AND MASK), ORed with STAT bit 7. This means bit 7 raises the line even when its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RXDATA) |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_valid | output | 1 | Transmit FIFO is not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_no_ack | input | 1 | No acknowledge pulse |
| evt_all_done | input | 1 | All packets complete pulse |
| evt_pkt_done | input | 1 | Packet transfer complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the one where the live data-request bits must be told apart from the sticky bits in the same register. Reaching it needs a programmed trigger, a FIFO filled to just below the trigger and then one word past it, and a write-one to STAT that must leave the request bits as they are. Each directed task builds exact fill levels through the engine and register interfaces before it samples STAT. A separate task drives an event pulse in the same cycle as a write-one clear, so that the case where both arrive together is exercised.

// File: rtl/sbfe_pkg.sv
package sbfe_pkg;
    localparam int WORD_W      = 32;
    localparam int FIFO_DEPTH  = 8;
    localparam int ADDR_W      = 3;
    localparam int TRIG_W      = 3;
    localparam int LVL_FIELD_W = 4;
    localparam int NUM_STAT    = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_LEVEL = 3'd1,
        RA_MASK  = 3'd2,
        RA_STAT  = 3'd3,
        RA_TXD   = 3'd4,
        RA_RXD   = 3'd5
    } reg_addr_e;

    // Packed order fixes the bit positions software decodes.
    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic [TRIG_W-1:0] rx_trig;
        logic              tx_flush;
        logic              rx_flush;
    } fifo_ctrl_t;

    typedef struct packed {
        logic pkt_done;
        logic all_done;
        logic tx_ovf;
        logic rx_unf;
        logic no_ack;
        logic arb_lost;
        logic tx_req;
        logic rx_req;
    } stat_vec_t;

    localparam logic [NUM_STAT-1:0] STICKY_BITS = 8'hFC;

    function automatic logic level_reached(input int level, input int trig);
        return level >= trig + 1;
    endfunction
endpackage

// File: rtl/sbfe_fifo.sv
module sbfe_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R6: the level never exceeds the storage
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R7: a flush leaves the FIFO empty
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);
    // R3/R4: a push into a full FIFO with no pop keeps the level
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> full);
endmodule

// File: rtl/sbfe_irq.sv
module sbfe_irq
    import sbfe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  stat_vec_t           evt,
    input  logic                live_rx_req,
    input  logic                live_tx_req,
    input  logic                wr_stat,
    input  logic                wr_mask,
    input  logic [NUM_STAT-1:0] wdata,
    output stat_vec_t           stat,
    output logic [NUM_STAT-1:0] mask,
    output logic                irq
);
    logic [NUM_STAT-1:0] sticky_q;
    logic [NUM_STAT-1:0] clr;

    assign clr = wr_stat ? (wdata & STICKY_BITS) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
            mask     <= '0;
        end else begin
            for (int i = 0; i < NUM_STAT; i++) begin
                if (STICKY_BITS[i])
                    sticky_q[i] <= (sticky_q[i] && !clr[i]) || evt[i];
                else
                    sticky_q[i] <= 1'b0;
            end
            if (wr_mask) mask <= wdata;
        end
    end

    always_comb begin
        stat        = stat_vec_t'(sticky_q);
        stat.rx_req = live_rx_req;
        stat.tx_req = live_tx_req;
    end

    assign irq = (|(stat & mask)) || stat.pkt_done;

    // R10: packet complete reaches the line whatever the mask holds
    p_pkt_unmaskable_r10: assert property (@(posedge clk) disable iff (rst)
        stat.pkt_done |-> irq);
    // R10: a zero mask with no packet complete keeps the line low
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (mask == '0 && !stat.pkt_done) |-> !irq);
    // R9: write-one clears a sticky bit when no event arrives
    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[3] && !evt.no_ack) |=> !stat.no_ack);
    // R9: a sticky bit holds unless cleared
    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (stat.arb_lost && !(wr_stat && wdata[2])) |=> stat.arb_lost);
    // R9: an event sets its bit even when cleared in the same cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        evt.pkt_done |=> stat.pkt_done);
endmodule

// File: rtl/sbfe_fifo_irq_unit.sv
module sbfe_fifo_irq_unit
    import sbfe_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic              eng_tx_pop,
    output logic [WIDTH-1:0]  eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_rx_push,
    input  logic [WIDTH-1:0]  eng_rx_data,
    input  logic              evt_arb_lost,
    input  logic              evt_no_ack,
    input  logic              evt_all_done,
    input  logic              evt_pkt_done,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    reg_addr_e   addr;
    fifo_ctrl_t  ctrl_q;
    stat_vec_t   stat, evt;
    logic [NUM_STAT-1:0] mask;
    logic        wr_ctrl, wr_stat, wr_mask, tx_push, rx_pop;
    logic [CW-1:0] tx_count, rx_count, tx_free;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [WIDTH-1:0] rx_head;
    logic        tx_req, rx_req;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_ctrl = reg_wr && addr == RA_CTRL;
    assign wr_stat = reg_wr && addr == RA_STAT;
    assign wr_mask = reg_wr && addr == RA_MASK;
    assign tx_push = reg_wr && addr == RA_TXD;
    assign rx_pop  = reg_rd && addr == RA_RXD;

    // Flush bits live exactly one cycle: set by the write, cleared as the
    // FIFO empties on the following edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= fifo_ctrl_t'(reg_wdata[NUM_STAT-1:0]);
        end else begin
            ctrl_q.tx_flush <= 1'b0;
            ctrl_q.rx_flush <= 1'b0;
        end
    end

    sbfe_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (ctrl_q.tx_flush),
        .push  (tx_push),
        .wdata (reg_wdata),
        .pop   (eng_tx_pop),
        .rdata (eng_tx_data),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sbfe_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (ctrl_q.rx_flush),
        .push  (eng_rx_push),
        .wdata (eng_rx_data),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign eng_tx_valid = !tx_empty;
    assign tx_free      = CW'(DEPTH) - tx_count;
    assign tx_req       = level_reached(int'(tx_free), int'(ctrl_q.tx_trig));
    assign rx_req       = level_reached(int'(rx_count), int'(ctrl_q.rx_trig));

    always_comb begin
        evt          = '0;
        evt.arb_lost = evt_arb_lost;
        evt.no_ack   = evt_no_ack;
        evt.all_done = evt_all_done;
        evt.pkt_done = evt_pkt_done;
        evt.tx_ovf   = tx_push && tx_full && !ctrl_q.tx_flush;
        evt.rx_unf   = rx_pop && rx_empty && !ctrl_q.rx_flush;
    end

    sbfe_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .live_rx_req (rx_req),
        .live_tx_req (tx_req),
        .wr_stat     (wr_stat),
        .wr_mask     (wr_mask),
        .wdata       (reg_wdata[NUM_STAT-1:0]),
        .stat        (stat),
        .mask        (mask),
        .irq         (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_CTRL:  reg_rdata[NUM_STAT-1:0] = ctrl_q;
            RA_LEVEL: reg_rdata[2*LVL_FIELD_W-1:0] =
                          {LVL_FIELD_W'(tx_free), LVL_FIELD_W'(rx_count)};
            RA_MASK:  reg_rdata[NUM_STAT-1:0] = mask;
            RA_STAT:  reg_rdata[NUM_STAT-1:0] = stat;
            RA_RXD:   reg_rdata = rx_head;
            default:  reg_rdata = '0;
        endcase
    end

    // R3: a push into a full transmit FIFO flags overflow
    p_tx_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full && !ctrl_q.tx_flush) |=> stat.tx_ovf);
    // R5: an empty receive read flags underflow
    p_rx_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty && !ctrl_q.rx_flush) |=> stat.rx_unf);
    // R7: a flush bit clears itself when not rewritten
    p_flush_selfclear_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.tx_flush && !wr_ctrl) |=> !ctrl_q.tx_flush);
    // R5: an empty receive FIFO reads as zero
    p_rx_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_RXD && rx_empty) |-> reg_rdata == '0);
    // R2: the engine sees no valid word from an empty FIFO
    p_tx_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_count == '0) |-> !eng_tx_valid);
endmodule

// File: tb/tb_sbfe_fifo_irq_unit.sv
module tb_sbfe_fifo_irq_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        eng_tx_pop = 0;
    logic [31:0] eng_tx_data;
    logic        eng_tx_valid;
    logic        eng_rx_push = 0;
    logic [31:0] eng_rx_data = 0;
    logic        evt_arb_lost = 0, evt_no_ack = 0, evt_all_done = 0, evt_pkt_done = 0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] A_CTRL = 0, A_LVL = 1, A_MASK = 2, A_STAT = 3, A_TXD = 4, A_RXD = 5;

    always #5 clk = ~clk;

    sbfe_fifo_irq_unit dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .evt_arb_lost(evt_arb_lost), .evt_no_ack(evt_no_ack),
        .evt_all_done(evt_all_done), .evt_pkt_done(evt_pkt_done), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1; #1; d = reg_rdata;
        tick();
        reg_rd = 0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        eng_rx_push = 1; eng_rx_data = d;
        tick();
        eng_rx_push = 0;
    endtask

    task automatic eng_pop();
        eng_tx_pop = 1;
        tick();
        eng_tx_pop = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(A_CTRL, v); check("R1", "ctrl", v, 0);
        peek(A_LVL, v);  check("R1", "level", v, 32'h80);
        peek(A_MASK, v); check("R1", "mask", v, 0);
        peek(A_STAT, v); check("R1", "stat", v, 32'h02);
        check("R1", "irq", irq, 0);
        check("R1", "tx valid", eng_tx_valid, 0);
    endtask

    task automatic t_tx_order();
        logic [31:0] v;
        eng_pop();
        check("R2", "pop on empty valid", eng_tx_valid, 0);
        wr(A_TXD, 32'hA1A1_0001);
        wr(A_TXD, 32'hB2B2_0002);
        wr(A_TXD, 32'hC3C3_0003);
        peek(A_LVL, v); check("R6", "level after 3 tx", v, 32'h50);
        check("R2", "valid", eng_tx_valid, 1);
        check("R2", "word0", eng_tx_data, 32'hA1A1_0001);
        eng_pop();
        check("R2", "word1", eng_tx_data, 32'hB2B2_0002);
        eng_pop();
        check("R2", "word2", eng_tx_data, 32'hC3C3_0003);
        eng_pop();
        check("R2", "valid after drain", eng_tx_valid, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) wr(A_TXD, 32'h100 + i);
        peek(A_STAT, v); check("R3", "no ovf at full", v[5], 0);
        peek(A_LVL, v);  check("R6", "level full tx", v, 32'h00);
        wr(A_TXD, 32'hDEAD);
        peek(A_STAT, v); check("R3", "ovf set", v[5], 1);
        peek(A_LVL, v);  check("R3", "level unchanged", v, 32'h00);
        check("R3", "head kept", eng_tx_data, 32'h100);
        wr(A_STAT, 32'h20);
        peek(A_STAT, v); check("R9", "ovf cleared", v[5], 0);
        wr(A_CTRL, 32'h02);
        peek(A_CTRL, v); check("R7", "tx flush busy", v, 32'h02);
        tick();
        peek(A_CTRL, v); check("R7", "tx flush done", v, 32'h00);
        peek(A_LVL, v);  check("R7", "tx empty after flush", v, 32'h80);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        eng_push(32'h1111_AAAA);
        eng_push(32'h2222_BBBB);
        peek(A_LVL, v); check("R6", "level rx 2", v, 32'h82);
        rd(A_RXD, v); check("R4", "rx word0", v, 32'h1111_AAAA);
        rd(A_RXD, v); check("R4", "rx word1", v, 32'h2222_BBBB);
        peek(A_STAT, v); check("R5", "no unf yet", v[4], 0);
        rd(A_RXD, v); check("R5", "empty read zero", v, 0);
        peek(A_STAT, v); check("R5", "unf set", v[4], 1);
        wr(A_STAT, 32'h10);
        for (int i = 0; i < 9; i++) eng_push(32'h200 + i);
        peek(A_LVL, v); check("R4", "rx full level", v, 32'h88);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXD, v); check("R4", "rx full order", v, 32'h200 + i);
        end
        peek(A_STAT, v); check("R4", "rx drop no flag", v, 32'h02);
        eng_push(32'h5);
        eng_push(32'h6);
        wr(A_CTRL, 32'h01);
        peek(A_CTRL, v); check("R7", "rx flush busy", v, 32'h01);
        tick();
        peek(A_CTRL, v); check("R7", "rx flush done", v, 0);
        peek(A_LVL, v);  check("R7", "rx empty after flush", v, 32'h80);
    endtask

    task automatic t_triggers();
        logic [31:0] v;
        wr(A_CTRL, 32'h88);   // tx trigger 4, rx trigger 2
        peek(A_STAT, v); check("R8", "tx req free8", v[1:0], 2'b10);
        for (int i = 0; i < 3; i++) wr(A_TXD, i);
        peek(A_STAT, v); check("R8", "tx req free5", v[1], 1);
        wr(A_TXD, 3);
        peek(A_STAT, v); check("R8", "tx req free4", v[1], 0);
        eng_push(1); eng_push(2);
        peek(A_STAT, v); check("R8", "rx req cnt2", v[0], 0);
        eng_push(3);
        peek(A_STAT, v); check("R8", "rx req cnt3", v[0], 1);
        wr(A_STAT, 32'h03);
        peek(A_STAT, v); check("R8", "req ignore w1c", v, 32'h01);
        wr(A_CTRL, 32'h03);
        tick();
        peek(A_STAT, v); check("R8", "req after flush", v, 32'h02);
    endtask

    task automatic t_events();
        logic [31:0] v;
        evt_arb_lost = 1; tick(); evt_arb_lost = 0;
        peek(A_STAT, v); check("R9", "arb set", v, 32'h06);
        wr(A_STAT, 32'h00);
        peek(A_STAT, v); check("R9", "write 0 keeps", v, 32'h06);
        wr(A_STAT, 32'h04);
        peek(A_STAT, v); check("R9", "w1c arb", v, 32'h02);
        evt_no_ack = 1; evt_all_done = 1; tick();
        evt_no_ack = 0; evt_all_done = 0;
        peek(A_STAT, v); check("R9", "nack+all", v, 32'h4A);
        evt_no_ack = 1; reg_wr = 1; reg_addr = A_STAT; reg_wdata = 32'h08;
        tick();
        evt_no_ack = 0; reg_wr = 0;
        peek(A_STAT, v); check("R9", "set wins", v[3], 1);
        evt_pkt_done = 1; tick(); evt_pkt_done = 0;
        peek(A_STAT, v); check("R9", "pkt set", v, 32'hCA);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        check("R10", "pkt unmasked irq", irq, 1);
        wr(A_STAT, 32'h80);
        #1 check("R10", "mask0 no irq", irq, 0);
        wr(A_MASK, 32'h08);
        #1 check("R10", "nack masked in", irq, 1);
        wr(A_STAT, 32'hFC);
        #1 check("R10", "cleared irq low", irq, 0);
        wr(A_MASK, 32'h02);
        #1 check("R10", "tx req irq", irq, 1);
        peek(A_MASK, v); check("R10", "mask readback", v, 32'h02);
        wr(A_MASK, 32'h00);
        #1 check("R10", "mask off", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_tx_order();
        t_overflow();
        t_rx();
        t_triggers();
        t_events();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule